// File: doc/BRIEF.md
# Two-wire Serial Memory Slave Engine

This block is the slave end of a two-wire serial memory. It runs on a fast system clock and treats the bus clock and bus data as slow inputs. Each bus line passes through a two-flop synchronizer. Edges of the bus clock are found by comparing successive samples. Start and stop conditions are decoded the same way. The block drives the data line only through an open-drain pull-down enable. It never drives a one.

After a start, the engine shifts in a device word. It checks a fixed selector nibble and a strap or page field, and acknowledges on the ninth clock. In write mode it then takes a word address and any number of data bytes. Each data byte goes into an internal register array and is also handed, with its address, to a separate page-write block. That block reports through `wr_busy` whether its timed write cycle is still running. In read mode the engine shifts out bytes from its internal address pointer for as long as the master acknowledges.

With the default `ADDR_W` of 10 the array holds 1 KB. One device-word bit is compared against a strap pin. Two device-word bits select the page, forming the top of the word address.

Top module: `twi_mem_slave`

## Requirements
- R1: A start condition (data falling while the bus clock is high) restarts device-word reception from any state, including in the middle of a byte. A stop condition (data rising while the clock is high) returns the engine to idle from any state. A byte cut short by either is not acknowledged and produces no write.
- R2: A device word is acknowledged only when its bits 7..4 equal 1010. Its bit 0 chooses the operation: 1 reads, 0 writes.
- R3: With ADDR_W = 10, device-word bit 3 must equal `strap[2]`. Bits 2..1 are page bits and are not compared. `strap[1:0]` is ignored.
- R4: An acknowledge pulls the data line low from the clock falling edge after the eighth bit until the falling edge that ends the ninth clock. The line is released after that edge.
- R5: In write mode the byte after the device word is the word address. The pointer becomes {page bits of that write-mode device word, address byte}.
- R6: Each write data byte is acknowledged. It is presented on `wr_addr`/`wr_data` with a one-cycle `wr_strobe` and stored in the array. After each byte the low 4 pointer bits increment and wrap within the 16-byte page, so 0x1FF is followed by 0x1F0.
- R7: `wr_done` pulses for one cycle after a stop that ends a write transfer that carried at least one data byte. A stop after a read, or after an address-only write, gives no pulse.
- R8: While `wr_busy` is high, a matching device word is not acknowledged. Once busy clears, the same word is acknowledged.
- R9: A read device word returns the byte at the pointer, which holds the last accessed address plus one. The page bits of a read device word have no effect.
- R10: In a read, each master acknowledge makes the engine send the next byte. The pointer wraps from 0x3FF to 0x000. A master not-acknowledge ends the read.
- R11: The data-line enable changes only while the bus clock is low.
- R12: After reset the data line is released and `wr_strobe` and `wr_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level as seen on the wire |
| strap | input | 3 | Hard-wired address straps |
| wr_busy | input | 1 | Page-write block reports a write cycle in progress |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_strobe | output | 1 | One-cycle pulse per received write byte |
| wr_addr | output | ADDR_W | Array address of the strobed byte |
| wr_data | output | 8 | Strobed write byte |
| wr_done | output | 1 | Write transfer closed by a stop |

## Verification
A bit counter that drifts by one appears at the ports within one byte: the acknowledge lands on the wrong clock, so the master reads a one on its ninth clock. A bad pointer does not show at once. It appears as wrong data on the next current-address or sequential read. That is why the tests chain writes, page wraps and reads and compare the returned bytes. A state left stuck after an abort shows up as a missing acknowledge on the next device word.

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
module twi_mem_slave #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap,
  input  logic              wr_busy,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_done
);
  localparam int NPG = ADDR_W - 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] CMP_MASK = 3'(3'b111 << NPG);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADR, S_WADR_ACK, S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } st_t;

  logic [2:0] scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [ADDR_W-1:0] ptr;
  logic [2:0] pg;
  logic is_rd, mack, got_data;
  logic [7:0] mem [DEPTH];

  wire scl_s     = scl_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire byte_end  = scl_fall & (cnt == 4'd8);

  wire dev_hit = (sh[7:4] == 4'b1010) && (((sh[3:1] ^ strap) & CMP_MASK) == 3'b000) && !wr_busy;
  wire [ADDR_W-1:0] word_addr = ADDR_W'({pg, sh});
  wire [ADDR_W-1:0] ptr_page = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  wire [7:0] rdata = mem[ptr];

  logic in_idle, dev_last;
  assign in_idle  = (st == S_IDLE);
  assign dev_last = (st == S_DEV) && byte_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_strobe) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      pg        <= '0;
      is_rd     <= 1'b0;
      mack      <= 1'b0;
      got_data  <= 1'b0;
      sda_oe    <= 1'b0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_done   <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      wr_done   <= 1'b0;
      if (start_det) begin
        st       <= S_DEV;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_det) begin
        if (got_data && (st == S_WDAT || st == S_WDAT_ACK)) wr_done <= 1'b1;
        st       <= S_IDLE;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_WADR, S_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_q[1]};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == S_DEV) begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  is_rd  <= sh[0];
                  if (!sh[0]) pg <= sh[3:1];
                  st     <= S_DEV_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_WADR) begin
                sda_oe <= 1'b1;
                ptr    <= word_addr;
                st     <= S_WADR_ACK;
              end else begin
                sda_oe    <= 1'b1;
                wr_strobe <= 1'b1;
                wr_addr   <= ptr;
                wr_data   <= sh;
                ptr       <= ptr_page;
                got_data  <= 1'b1;
                st        <= S_WDAT_ACK;
              end
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              if (is_rd) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
                ptr    <= ptr + ADDR_W'(1);
                cnt    <= '0;
                st     <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WADR;
              end
            end
          end
          S_WADR_ACK, S_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= S_WDAT;
              if (st == S_WADR_ACK) got_data <= 1'b0;
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else if (scl_fall) begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_q[1];
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
                ptr    <= ptr + ADDR_W'(1);
                cnt    <= '0;
                st     <= S_RDAT;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module twi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic wr_strobe,
  input logic wr_done,
  input logic stop_det,
  input logic in_idle,
  input logic dev_last,
  input logic wr_busy
);
  a_r11_oe_moves_low_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));
  a_r6_strobe_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> sda_oe);
  a_r7_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(stop_det));
  a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_last && wr_busy) |=> (!sda_oe && in_idle));
  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);
  a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_strobe, wr_done}));
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_strobe(wr_strobe), .wr_done(wr_done), .stop_det(stop_det),
  .in_idle(in_idle), .dev_last(dev_last), .wr_busy(wr_busy)
);

// File: tb/twi_mem_slave_tb.sv
`timescale 1ns/1ps
module twi_mem_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wr_busy;
  logic sda_oe, wr_strobe, wr_done;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_bus = m_sda & ~sda_oe;

  int total = 0, bad = 0;
  int done_cnt = 0, stb_cnt = 0, viol = 0, busy_cnt = 0;
  logic [9:0] log_addr [8];
  logic [7:0] log_data [8];
  logic rel;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  twi_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .strap(strap),
    .wr_busy(wr_busy), .sda_oe(sda_oe), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_done(wr_done)
  );

  assign wr_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (wr_done) done_cnt <= done_cnt + 1;
    if (wr_strobe) begin
      if (stb_cnt < 8) begin
        log_addr[stb_cnt] <= wr_addr;
        log_data[stb_cnt] <= wr_data;
      end
      stb_cnt <= stb_cnt + 1;
    end
    if (wr_done) busy_cnt <= 1500;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (rst_n && (sda_oe !== prev_oe) && m_scl) viol <= viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qd();
    repeat (8) @(negedge clk);
  endtask

  task automatic start();
    m_sda = 1'b1; qd(); m_scl = 1'b1; qd(); m_sda = 1'b0; qd(); m_scl = 1'b0; qd();
  endtask

  task automatic stop();
    m_sda = 1'b0; qd(); m_scl = 1'b1; qd(); m_sda = 1'b1; qd();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; qd(); m_scl = 1'b1; qd(); qd(); m_scl = 1'b0; qd();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; qd(); m_scl = 1'b1; qd(); ack = ~sda_bus; qd(); m_scl = 1'b0; qd();
    rel = ~sda_oe;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      qd(); m_scl = 1'b1; qd(); b = {b[6:0], sda_bus}; qd(); m_scl = 1'b0;
    end
    m_sda = ~give_ack; qd(); m_scl = 1'b1; qd(); qd(); m_scl = 1'b0; qd(); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dw(input logic [1:0] pp, input logic rd);
    return {4'hA, 1'b1, pp, rd};
  endfunction

  task automatic wait_free();
    qd();
    while (wr_busy) @(negedge clk);
  endtask

  task automatic wr_txn(input string tag, input logic [1:0] pp, input logic [7:0] a,
                        input int n, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    stb_cnt = 0;
    start();
    send_byte(dw(pp, 1'b0), ack); check({tag, " dev ack"}, ack, 1);
    send_byte(a, ack); check({tag, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); check({tag, " data ack"}, ack, 1);
    end
    stop();
  endtask

  task automatic t_reset();
    check("R12 oe after reset", sda_oe, 0);
    check("R12 strobe after reset", wr_strobe, 0);
    check("R12 done after reset", wr_done, 0);
  endtask

  task automatic t_write_page();
    int d0;
    d0 = done_cnt;
    wr_txn("R2 R3 R5 R6", 2'b01, 8'hF0, 3, 8'h11, 8'h22, 8'h33);
    check("R4 released after ninth clock", rel, 1);
    qd();
    check("R6 strobe count", stb_cnt, 3);
    check("R5 first addr", log_addr[0], 10'h1F0);
    check("R6 third addr", log_addr[2], 10'h1F2);
    check("R6 third data", log_data[2], 8'h33);
    check("R7 done pulse", done_cnt, d0 + 1);
  endtask

  task automatic t_busy_poll();
    logic ack;
    int d0;
    start(); send_byte(dw(2'b01, 1'b0), ack); stop();
    check("R8 no ack while busy", ack, 0);
    wait_free();
    d0 = done_cnt;
    start(); send_byte(dw(2'b01, 1'b0), ack); stop();
    check("R8 ack after busy", ack, 1);
    qd();
    check("R7 no done without data", done_cnt, d0);
  endtask

  task automatic t_page_wrap();
    wr_txn("R6 wrap", 2'b01, 8'hFE, 3, 8'h44, 8'h55, 8'h66);
    qd();
    check("R6 page wrap addr", log_addr[2], 10'h1F0);
    wait_free();
  endtask

  task automatic t_random_read();
    logic ack;
    logic [7:0] b;
    int d0;
    d0 = done_cnt;
    start(); send_byte(dw(2'b01, 1'b0), ack); send_byte(8'hF0, ack);
    start(); send_byte(dw(2'b10, 1'b1), ack);
    check("R9 read dev ack", ack, 1);
    recv_byte(1'b1, b); check("R10 random byte 1F0", b, 8'h66);
    recv_byte(1'b0, b); check("R10 sequential byte 1F1", b, 8'h22);
    stop(); qd();
    check("R7 no done after read", done_cnt, d0);
    start(); send_byte(dw(2'b00, 1'b1), ack);
    recv_byte(1'b0, b); stop();
    check("R9 current read 1F2", b, 8'h33);
  endtask

  task automatic t_bad_addr();
    logic ack;
    start(); send_byte(8'hA2, ack); stop();
    check("R3 strap mismatch no ack", ack, 0);
    start(); send_byte(8'hB2, ack); stop();
    check("R2 nibble mismatch no ack", ack, 0);
    strap = 3'b110;
    start(); send_byte(dw(2'b01, 1'b1), ack);
    if (ack) begin logic [7:0] b; recv_byte(1'b0, b); end
    stop();
    check("R3 low straps ignored", ack, 1);
    strap = 3'b101;
  endtask

  task automatic t_array_wrap();
    logic ack;
    logic [7:0] b;
    wr_txn("R10 top", 2'b11, 8'hFF, 1, 8'h5A, 8'h00, 8'h00); wait_free();
    wr_txn("R10 bottom", 2'b00, 8'h00, 1, 8'hA5, 8'h00, 8'h00); wait_free();
    start(); send_byte(dw(2'b11, 1'b0), ack); send_byte(8'hFF, ack);
    start(); send_byte(dw(2'b00, 1'b1), ack);
    recv_byte(1'b1, b); check("R10 byte 3FF", b, 8'h5A);
    recv_byte(1'b0, b); check("R10 wrap to 000", b, 8'hA5);
    stop();
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] b;
    int d0;
    start(); send_byte(dw(2'b01, 1'b0), ack);
    send_bits(8'hF0, 4);
    start(); send_byte(dw(2'b01, 1'b1), ack);
    check("R1 restart mid byte acked", ack, 1);
    recv_byte(1'b0, b); stop();
    d0 = done_cnt;
    stb_cnt = 0;
    start(); send_byte(dw(2'b01, 1'b0), ack); send_byte(8'hF4, ack);
    send_bits(8'h77, 3); stop(); qd();
    check("R1 stop mid byte no strobe", stb_cnt, 0);
    check("R1 stop mid byte no done", done_cnt, d0);
    check("R1 stop mid byte released", sda_oe, 0);
    start(); send_byte(dw(2'b01, 1'b1), ack);
    check("R1 next transfer acked", ack, 1);
    recv_byte(1'b0, b); stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    qd();
    t_write_page();
    t_busy_poll();
    t_page_wrap();
    t_random_read();
    t_bad_addr();
    t_array_wrap();
    t_abort();
    check("R11 oe changes with clock low", viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule